// File: doc/BRIEF.md
# Host Port Strobe Sequencer

This block is the host-side master for a parallel host-port bus. The target on that bus sees a single effective strobe. It is active low and is formed from chip select and two data strobes: the strobe counts as low only while chip select is low and the two data strobes differ. When idle, the block accepts one access request at a time. A request carries a 2-bit control field, a read/write flag, a halfword-select flag and write data. The block then walks the bus through a timed sequence. The sequence is select setup, an optional address-strobe latch phase, the strobe-low phase, a wait on the target's active-low ready, data hold, and a recovery gap. At the end the block returns read data and a one-cycle done pulse.

Every interval is a count of controller clock cycles. Each count is derived at elaboration from a nanosecond minimum, rounded up at the controller clock period. The recovery gap comes from the target's clock figure M and is at least 2M ns. The ready input is resynchronised through two flops. A cycle counter bounds the wait on ready. If the target never answers, the access is aborted and flagged.

The state sequence is IDLE, SETUP, LATCH (in latch mode only), STB_LOW, WAIT_RDY, HOLD, GAP, then back to IDLE. The transitions are:
- IDLE to SETUP when a request is presented.
- SETUP to LATCH, or straight to STB_LOW, when the setup count expires.
- LATCH to STB_LOW when the latch count expires.
- STB_LOW to WAIT_RDY when the minimum strobe width has elapsed.
- WAIT_RDY to HOLD when the synchronised ready reads low, or when the timeout count expires.
- HOLD to GAP when the hold count expires. Done pulses on that transition.
- GAP to IDLE when the gap count expires.

Top module: `hpi_strobe_seq`

## Requirements
- R1: After reset, chip select, both data strobes and the address strobe are high. The data-bus enable, busy, done and timeout flag are all low.
- R2: Chip select is low, and the select lines (control field, read/write, halfword) carry the request, for at least SETUP_CYC = ceil(5 ns / clock period) cycles before the effective strobe falls.
- R3: While chip select stays low, the select lines do not change.
- R4: The strobe is driven by data strobe 1 low and data strobe 2 high, with chip select low. It stays low for at least STB_CYC = ceil(15 ns / clock period) cycles.
- R5: The strobe is released only once the two-flop-synchronised ready reads low. With ready falling d cycles after the strobe falls, the strobe stays low for exactly max(STB_CYC, d+2)+1 cycles.
- R6: On a write, the data-bus enable is high from the start of setup until the end of hold, and the driven data equals the request data and stays stable. On a read or in idle, the enable stays low.
- R7: In latch mode, the address strobe falls at least ceil(2 ns / clock period) cycles before the strobe falls and is still low when it falls.
- R8: Between consecutive accesses, the strobe stays high for at least ceil(2M / clock period) cycles.
- R9: Done is high for exactly one cycle per access. It is high in the last hold cycle, while the strobe is already high.
- R10: On a read, the read-data output takes the data-bus input sampled on the cycle the strobe is released, and holds it afterwards.
- R11: If ready stays high for TIMEOUT_CYC cycles in WAIT_RDY, the strobe is released and the timeout flag is set. The flag stays set until the next accepted request. Done still pulses, and read data keeps its old value.
- R12: A request presented while busy is ignored. It starts no further access, and it changes no select line of the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_cntl | input | 2 | Control field of the request |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_hw | input | 1 | Halfword select of the request |
| req_wdata | input | DW | Write data |
| busy | output | 1 | High from acceptance until back in IDLE |
| done | output | 1 | One-cycle end-of-access pulse |
| timeout_err | output | 1 | Ready wait expired on the last access |
| rd_data | output | DW | Captured read data |
| hpi_cntl | output | 2 | Control field to target |
| hpi_rnw | output | 1 | Read/write select to target |
| hpi_hw | output | 1 | Halfword select to target |
| hpi_as_n | output | 1 | Address-strobe latch, active low |
| hpi_cs_n | output | 1 | Chip select, active low |
| hpi_ds1_n | output | 1 | Data strobe 1 |
| hpi_ds2_n | output | 1 | Data strobe 2 |
| hpi_rdy_n | input | 1 | Target ready, active low, asynchronous |
| hd_in | input | DW | Data bus from target |
| hd_out | output | DW | Data bus to target |
| hd_oe | output | 1 | Data-bus drive enable |

## Verification
The hardest case to reach is the timing of ready relative to the two-flop synchroniser and the minimum strobe width. A ready that comes early must still leave the strobe at its minimum width, and a late one must stretch the strobe by exactly the synchroniser delay. The missing ready that drives the timeout path cannot happen with a well-behaved target at all. The bench therefore models the target as a responder with a programmable ready delay. It sweeps that delay across the points where the synchroniser latency crosses the minimum width, and it also has a setting that never answers.

// File: rtl/hpi_seq_pkg.sv
package hpi_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LATCH,
        ST_STB_LOW,
        ST_WAIT_RDY,
        ST_HOLD,
        ST_GAP
    } seq_state_e;

    // Round a nanosecond minimum up to whole clock cycles, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hpi_rdy_sync.sv
module hpi_rdy_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_n_async,
    output logic rdy_n_sync
);
    logic stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1     <= 1'b1;
            rdy_n_sync <= 1'b1;
        end else begin
            stage1     <= rdy_n_async;
            rdy_n_sync <= stage1;
        end
    end
endmodule

// File: rtl/hpi_seq_timer.sv
module hpi_seq_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/hpi_strobe_seq.sv
module hpi_strobe_seq
    import hpi_seq_pkg::*;
#(
    parameter int DW           = 16,
    parameter int CLK_NS       = 4,
    parameter int M_NS         = 10,
    parameter bit LATCH_MODE   = 1'b1,
    parameter int TIMEOUT_CYC  = 20,
    parameter int SEL_SETUP_NS = 5,
    parameter int SEL_HOLD_NS  = 2,
    parameter int STB_LOW_NS   = 15,
    parameter int DAT_SETUP_NS = 5,
    parameter int DAT_HOLD_NS  = 2,
    parameter int AS_LEAD_NS   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_cntl,
    input  logic          req_rnw,
    input  logic          req_hw,
    input  logic [DW-1:0] req_wdata,
    output logic          busy,
    output logic          done,
    output logic          timeout_err,
    output logic [DW-1:0] rd_data,
    output logic [1:0]    hpi_cntl,
    output logic          hpi_rnw,
    output logic          hpi_hw,
    output logic          hpi_as_n,
    output logic          hpi_cs_n,
    output logic          hpi_ds1_n,
    output logic          hpi_ds2_n,
    input  logic          hpi_rdy_n,
    input  logic [DW-1:0] hd_in,
    output logic [DW-1:0] hd_out,
    output logic          hd_oe
);
    localparam int SETUP_CYC = ns_to_cyc(SEL_SETUP_NS, CLK_NS);
    localparam int AS_CYC    = ns_to_cyc(AS_LEAD_NS, CLK_NS);
    localparam int STB_CYC   = imax(ns_to_cyc(STB_LOW_NS, CLK_NS),
                                    ns_to_cyc(DAT_SETUP_NS, CLK_NS));
    localparam int HOLD_CYC  = imax(ns_to_cyc(DAT_HOLD_NS, CLK_NS),
                                    ns_to_cyc(SEL_HOLD_NS, CLK_NS));
    localparam int GAP_MIN   = ns_to_cyc(2 * M_NS, CLK_NS);
    localparam int GAP_CYC   = (GAP_MIN > HOLD_CYC) ? (GAP_MIN - HOLD_CYC) : 1;
    localparam int TMO_CYC   = (TIMEOUT_CYC < 1) ? 1 : TIMEOUT_CYC;
    localparam int TW        = $clog2(TMO_CYC + GAP_CYC + STB_CYC + SETUP_CYC
                                      + AS_CYC + HOLD_CYC + 1) + 1;

    seq_state_e    state, state_d;
    logic          rdy_s;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          timeout_hit, rdy_hit;
    logic          as_phase, oe_win;

    logic [1:0]    cntl_q;
    logic          rnw_q, hw_q, err_q;
    logic [DW-1:0] wdata_q, rdata_q;

    hpi_rdy_sync u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .rdy_n_async (hpi_rdy_n),
        .rdy_n_sync  (rdy_s)
    );

    hpi_seq_timer #(.TW(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    assign rdy_hit     = (state == ST_WAIT_RDY) && !rdy_s;
    assign timeout_hit = (state == ST_WAIT_RDY) && rdy_s && tmr_zero;

    // Next-state selection
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:     if (req_valid) state_d = ST_SETUP;
            ST_SETUP:    if (tmr_zero)  state_d = LATCH_MODE ? ST_LATCH : ST_STB_LOW;
            ST_LATCH:    if (tmr_zero)  state_d = ST_STB_LOW;
            ST_STB_LOW:  if (tmr_zero)  state_d = ST_WAIT_RDY;
            ST_WAIT_RDY: if (rdy_hit || timeout_hit) state_d = ST_HOLD;
            ST_HOLD:     if (tmr_zero)  state_d = ST_GAP;
            ST_GAP:      if (tmr_zero)  state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // Duration of the state being entered
    always_comb begin
        tmr_load = (state_d != state);
        unique case (state_d)
            ST_SETUP:    tmr_val = TW'(SETUP_CYC - 1);
            ST_LATCH:    tmr_val = TW'(AS_CYC - 1);
            ST_STB_LOW:  tmr_val = TW'(STB_CYC - 1);
            ST_WAIT_RDY: tmr_val = TW'(TMO_CYC - 1);
            ST_HOLD:     tmr_val = TW'(HOLD_CYC - 1);
            ST_GAP:      tmr_val = TW'(GAP_CYC - 1);
            default:     tmr_val = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Request capture, read capture and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cntl_q  <= '0;
            rnw_q   <= 1'b1;
            hw_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                cntl_q  <= req_cntl;
                rnw_q   <= req_rnw;
                hw_q    <= req_hw;
                wdata_q <= req_wdata;
                err_q   <= 1'b0;
            end
            if (rdy_hit)     rdata_q <= hd_in;
            if (timeout_hit) err_q   <= 1'b1;
        end
    end

    // Bus outputs by state
    always_comb begin
        hpi_cs_n  = 1'b1;
        hpi_ds1_n = 1'b1;
        hpi_ds2_n = 1'b1;
        as_phase  = 1'b0;
        oe_win    = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE, ST_GAP: ;
            ST_SETUP: begin
                hpi_cs_n = 1'b0;
                oe_win   = 1'b1;
            end
            ST_LATCH: begin
                hpi_cs_n = 1'b0;
                as_phase = 1'b1;
                oe_win   = 1'b1;
            end
            ST_STB_LOW, ST_WAIT_RDY: begin
                hpi_cs_n  = 1'b0;
                hpi_ds1_n = 1'b0;
                as_phase  = 1'b1;
                oe_win    = 1'b1;
            end
            ST_HOLD: begin
                hpi_cs_n = 1'b0;
                oe_win   = 1'b1;
                done     = tmr_zero;
            end
            default: ;
        endcase
    end

    generate
        if (LATCH_MODE) begin : g_latch
            assign hpi_as_n = ~as_phase;
        end else begin : g_nolatch
            assign hpi_as_n = 1'b1;
        end
    endgenerate

    assign busy        = (state != ST_IDLE);
    assign timeout_err = err_q;
    assign rd_data     = rdata_q;
    assign hpi_cntl    = cntl_q;
    assign hpi_rnw     = rnw_q;
    assign hpi_hw      = hw_q;
    assign hd_out      = wdata_q;
    assign hd_oe       = oe_win & ~rnw_q;
endmodule

// File: rtl/hpi_strobe_seq_chk.sv
module hpi_strobe_seq_chk
    import hpi_seq_pkg::*;
#(
    parameter int DW           = 16,
    parameter int CLK_NS       = 4,
    parameter int M_NS         = 10,
    parameter bit LATCH_MODE   = 1'b1,
    parameter int SEL_SETUP_NS = 5,
    parameter int STB_LOW_NS   = 15,
    parameter int AS_LEAD_NS   = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    hpi_cntl,
    input logic          hpi_rnw,
    input logic          hpi_hw,
    input logic          hpi_as_n,
    input logic          hpi_cs_n,
    input logic          hpi_ds1_n,
    input logic          hpi_ds2_n,
    input logic          hpi_rdy_n,
    input logic [DW-1:0] hd_out,
    input logic          hd_oe,
    input logic          done,
    input logic          timeout_err
);
    localparam int SETUP_CYC = ns_to_cyc(SEL_SETUP_NS, CLK_NS);
    localparam int STB_MIN   = ns_to_cyc(STB_LOW_NS, CLK_NS);
    localparam int AS_MIN    = ns_to_cyc(AS_LEAD_NS, CLK_NS);
    localparam int GAP_MIN   = ns_to_cyc(2 * M_NS, CLK_NS);

    logic        stb_n;
    logic [15:0] sel_run, lo_run, hi_run, as_run;
    logic        seen_acc;

    assign stb_n = ~(hpi_ds1_n ^ hpi_ds2_n) | hpi_cs_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_run  <= '0;
            lo_run   <= '0;
            hi_run   <= '0;
            as_run   <= '0;
            seen_acc <= 1'b0;
        end else begin
            sel_run <= hpi_cs_n ? 16'd0 : ((sel_run == 16'hFFFF) ? sel_run : sel_run + 1'b1);
            lo_run  <= stb_n ? 16'd0 : ((lo_run == 16'hFFFF) ? lo_run : lo_run + 1'b1);
            hi_run  <= !stb_n ? 16'd0 : ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1);
            as_run  <= hpi_as_n ? 16'd0 : ((as_run == 16'hFFFF) ? as_run : as_run + 1'b1);
            if (!stb_n) seen_acc <= 1'b1;
        end
    end

    assert_sel_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stb_n) |-> (sel_run >= 16'(SETUP_CYC)));

    assert_sel_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hpi_cs_n && !$past(hpi_cs_n)) |-> ($stable(hpi_cntl) && $stable(hpi_rnw) && $stable(hpi_hw)));

    assert_stb_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb_n) |-> (lo_run >= 16'(STB_MIN)));

    assert_rdy_before_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stb_n) && !timeout_err) |-> ($past(hpi_rdy_n, 3) == 1'b0));

    assert_wdata_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hd_oe && $past(hd_oe)) |-> $stable(hd_out));

    assert_oe_write_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hd_oe |-> (!hpi_rnw && !hpi_cs_n));

    generate
        if (LATCH_MODE) begin : g_as_chk
            assert_as_lead_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(stb_n) |-> (!hpi_as_n && as_run >= 16'(AS_MIN)));
        end
    endgenerate

    assert_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stb_n) && seen_acc) |-> (hi_run >= 16'(GAP_MIN)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_stb_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (stb_n && !hpi_cs_n));
endmodule

bind hpi_strobe_seq hpi_strobe_seq_chk #(
    .DW           (DW),
    .CLK_NS       (CLK_NS),
    .M_NS         (M_NS),
    .LATCH_MODE   (LATCH_MODE),
    .SEL_SETUP_NS (SEL_SETUP_NS),
    .STB_LOW_NS   (STB_LOW_NS),
    .AS_LEAD_NS   (AS_LEAD_NS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hpi_cntl    (hpi_cntl),
    .hpi_rnw     (hpi_rnw),
    .hpi_hw      (hpi_hw),
    .hpi_as_n    (hpi_as_n),
    .hpi_cs_n    (hpi_cs_n),
    .hpi_ds1_n   (hpi_ds1_n),
    .hpi_ds2_n   (hpi_ds2_n),
    .hpi_rdy_n   (hpi_rdy_n),
    .hd_out      (hd_out),
    .hd_oe       (hd_oe),
    .done        (done),
    .timeout_err (timeout_err)
);

// File: tb/hpi_strobe_seq_test.sv
`timescale 1ns/1ps
module hpi_strobe_seq_test;
    localparam int DW      = 16;
    localparam int STB     = 4;   // ceil(15/4)
    localparam int SETUP   = 2;   // ceil(5/4)
    localparam int AS_MIN  = 1;   // ceil(2/4)
    localparam int GAP_MIN = 5;   // ceil(2*10/4)
    localparam int TMO     = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_cntl = '0;
    logic          req_rnw = 1'b0;
    logic          req_hw = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic          busy, done, timeout_err;
    logic [DW-1:0] rd_data;
    logic [1:0]    hpi_cntl;
    logic          hpi_rnw, hpi_hw, hpi_as_n, hpi_cs_n, hpi_ds1_n, hpi_ds2_n;
    logic          hpi_rdy_n = 1'b1;
    logic [DW-1:0] hd_in = '0;
    logic [DW-1:0] hd_out;
    logic          hd_oe;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    hpi_strobe_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cntl(req_cntl),
        .req_rnw(req_rnw), .req_hw(req_hw), .req_wdata(req_wdata),
        .busy(busy), .done(done), .timeout_err(timeout_err), .rd_data(rd_data),
        .hpi_cntl(hpi_cntl), .hpi_rnw(hpi_rnw), .hpi_hw(hpi_hw),
        .hpi_as_n(hpi_as_n), .hpi_cs_n(hpi_cs_n), .hpi_ds1_n(hpi_ds1_n),
        .hpi_ds2_n(hpi_ds2_n), .hpi_rdy_n(hpi_rdy_n), .hd_in(hd_in),
        .hd_out(hd_out), .hd_oe(hd_oe)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Target responder: ready falls d_cfg cycles after the strobe falls (-1 = never)
    int          d_cfg = 0;
    logic [DW-1:0] rsp_data = '0;
    int          rsp_cnt = 0;
    logic        stb_n;
    assign stb_n = ~(hpi_ds1_n ^ hpi_ds2_n) | hpi_cs_n;

    always @(negedge clk) begin
        if (!stb_n) begin
            if (d_cfg >= 0 && rsp_cnt >= d_cfg) begin
                hpi_rdy_n = 1'b0;
                hd_in     = rsp_data;
            end
            rsp_cnt++;
        end else begin
            hpi_rdy_n = 1'b1;
            hd_in     = '0;
            rsp_cnt   = 0;
        end
    end

    // Bus monitor
    logic       prev_low = 1'b0;
    int         lo_run = 0, hi_run = 1000, as_run = 0;
    int         len_last = 0, hi_at_fall = 0, as_at_fall_run = 0, fall_cnt = 0;
    logic [3:0] sel_at_fall = '0;
    logic       as_at_fall = 1'b1, oe_last = 1'b0, oe_any = 1'b0;
    logic [DW-1:0] wd_last = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (hd_oe) oe_any = 1'b1;
            if (!stb_n) begin
                if (!prev_low) begin
                    sel_at_fall    = {hpi_cntl, hpi_rnw, hpi_hw};
                    as_at_fall     = hpi_as_n;
                    as_at_fall_run = as_run;
                    hi_at_fall     = hi_run;
                    lo_run         = 0;
                    fall_cnt++;
                end
                lo_run++;
                wd_last = hd_out;
                oe_last = hd_oe;
            end else begin
                if (prev_low) begin
                    len_last = lo_run;
                    hi_run   = 0;
                end
                hi_run++;
            end
            as_run   = hpi_as_n ? 0 : as_run + 1;
            prev_low = !stb_n;
        end
    end

    int n_acc = 0;

    task automatic run_acc(input logic [1:0] c, input logic rw, input logic h,
                           input logic [DW-1:0] wd, input int d, input bit poke);
        logic [DW-1:0] prev_rd;
        int n, exp_len, falls_before;
        @(negedge clk);
        while (busy) @(negedge clk);
        d_cfg    = d;
        rsp_data = 16'hA5C3 ^ {8'(d), 4'(n_acc), c, rw, h};
        prev_rd  = rd_data;
        oe_any   = 1'b0;
        req_cntl = c; req_rnw = rw; req_hw = h; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 400) begin
            if (poke && n == 3) begin
                req_valid = 1'b1; req_cntl = ~c; req_rnw = ~rw; req_hw = ~h;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        chk(done === 1'b1, "R9 done seen", 32'(done), 1);
        chk(stb_n === 1'b1, "R9 strobe high at done", 32'(stb_n), 1);
        @(negedge clk);
        chk(done === 1'b0, "R9 done single cycle", 32'(done), 0);
        exp_len = (d < 0) ? (STB + TMO) : (((STB > d + 2) ? STB : d + 2) + 1);
        chk(len_last == exp_len, "R4/R5 strobe low length", 32'(len_last), 32'(exp_len));
        chk(len_last >= STB, "R4 minimum width", 32'(len_last), STB);
        chk(sel_at_fall == {c, rw, h}, "R2/R3 selects at strobe fall", 32'(sel_at_fall), 32'({c, rw, h}));
        chk(as_at_fall == 1'b0 && as_at_fall_run >= AS_MIN, "R7 address strobe lead",
            32'(as_at_fall_run), AS_MIN);
        if (!rw) chk(wd_last == wd && oe_last, "R6 write data driven", 32'(wd_last), 32'(wd));
        else     chk(oe_any == 1'b0, "R6 no drive on read", 32'(oe_any), 0);
        if (d < 0) begin
            chk(timeout_err === 1'b1, "R11 timeout flag", 32'(timeout_err), 1);
            chk(rd_data == prev_rd, "R11 read data kept", 32'(rd_data), 32'(prev_rd));
        end else begin
            chk(timeout_err === 1'b0, "R11 flag clear", 32'(timeout_err), 0);
            if (rw) chk(rd_data == rsp_data, "R10 read capture", 32'(rd_data), 32'(rsp_data));
        end
        if (n_acc > 0) chk(hi_at_fall >= GAP_MIN, "R8 gap between accesses", 32'(hi_at_fall), GAP_MIN);
        if (poke) begin
            falls_before = fall_cnt;
            repeat (30) @(negedge clk);
            chk(fall_cnt == falls_before, "R12 no extra access", 32'(fall_cnt), 32'(falls_before));
            chk(busy === 1'b0 && hpi_cs_n === 1'b1, "R12 idle after ignored request", 32'(busy), 0);
        end
        n_acc++;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hpi_cs_n && hpi_ds1_n && hpi_ds2_n && hpi_as_n, "R1 bus idle", 
            32'({hpi_cs_n, hpi_ds1_n, hpi_ds2_n, hpi_as_n}), 32'hF);
        chk(!hd_oe && !busy && !done && !timeout_err, "R1 flags low",
            32'({hd_oe, busy, done, timeout_err}), 0);
        for (int rw = 0; rw < 2; rw++)
            for (int h = 0; h < 2; h++)
                for (int c = 0; c < 4; c++)
                    for (int d = 0; d < 6; d++)
                        run_acc(2'(c), 1'(rw), 1'(h), 16'(16'h1234 + c * 16'h0111 + d * 16'h0F00 + h),
                                d, 1'b0);
        run_acc(2'd2, 1'b1, 1'b0, 16'h0, -1, 1'b0);   // R11 read timeout
        run_acc(2'd1, 1'b0, 1'b1, 16'hBEEF, -1, 1'b0); // R11 write timeout
        run_acc(2'd3, 1'b1, 1'b1, 16'h0, 1, 1'b0);     // R11 flag cleared by new request
        run_acc(2'd1, 1'b0, 1'b0, 16'h5A5A, 3, 1'b1);  // R12 request while busy
        run_acc(2'd2, 1'b1, 1'b0, 16'h0, 9, 1'b1);     // R12 on a read, late ready
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule